// File: doc/BRIEF.md
# Instruction Address Compare Debug Unit

This unit watches the address of each instruction as it executes and raises debug events when that address meets one of four programmed conditions. The four compare registers form two pairs: registers 1 and 2, and registers 3 and 4. Each pair works in one of two modes. In exact mode, each register of the pair is matched against the address on its own. In value/mask mode, one register holds a value and its partner holds a bit mask. Each event has an enable and a two-bit privilege qualifier. Every event that fires sets a sticky status bit.

Software programs the unit through a single write port. The port selects one of the compare registers, the control word, or the status clear. The core presents each executed address with a valid strobe. With the address it presents a flag for 32-bit computation mode and a flag for user (problem) state. A single-cycle event output tells downstream debug logic that at least one status bit has just become set.

Top module: `iac_debug_unit`

## Requirements
- R1: Status bit k-1 (`status[k-1]` for event k, k = 1..4) can only become set while enable bit k-1 of the control word is 1. The control word places the enables in bits [3:0], the pair 1/2 mode in bit 4, the pair 3/4 mode in bit 5, and the qualifier of event k in bits [2k+5:2k+4].
- R2: Status bits are sticky. A write with `wr_sel`=5 clears each status bit whose `wr_data` bit is 1 and leaves the others alone. If a bit is cleared and hit on the same edge, it stays set.
- R3: When a pair's mode bit is 0 (exact), event k fires when the compared address bits equal compare register k.
- R4: When a pair's mode bit is 1 (value/mask), the lower-numbered register of the pair holds the value and the higher-numbered one holds the mask. Address bits with mask 1 must equal the value. Address bits with mask 0 are ignored.
- R5: A value/mask match sets the status bit of every event in the pair whose enable and qualifier allow it: one bit, or both.
- R6: When `mode32` is 1, only the lower half of the address (bits [ADDR_W/2-1:0]) is compared. This applies in both modes.
- R7: A qualifier of 00 ignores `user_mode`. A qualifier of 10 needs `user_mode`=0. A qualifier of 11 needs `user_mode`=1. A qualifier of 01 never matches.
- R8: A comparison happens only on a cycle where `addr_valid` is 1. With `addr_valid` at 0, no status bit is set and `dbg_event` stays low.
- R9: `dbg_event` goes high for one cycle, on the same edge that sets the status bits. It fires only if at least one of those bits was previously clear.
- R10: A pair in value/mask mode with both of its enables clear produces no status bits and no event.
- R11: `wr_sel` values 0 to 3 load compare registers 1 to 4, and value 4 loads the control word. A write takes effect for addresses presented on later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_valid | input | 1 | Address strobe for an executed instruction |
| addr | input | ADDR_W | Instruction address |
| mode32 | input | 1 | 1 = 32-bit computation mode (upper half ignored) |
| user_mode | input | 1 | 1 = problem (user) state |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | ADDR_W | Write data |
| status | output | 4 | Sticky event status, bit k-1 for event k |
| dbg_event | output | 1 | One-cycle pulse when a status bit newly sets |

## Verification
The bench builds the unit with ADDR_W=16. At that width a 32-bit-mode comparison ignores an 8-bit upper half, so a sweep of a few hundred arithmetically derived configurations covers many cases. It reaches every mode pairing, every qualifier code against both privilege states, and every enable pattern. It also tries addresses that are exact copies, upper-half perturbations and unrelated values of the compare registers. Directed sequences cover stickiness, partial clears, clear-and-set collisions, idle strobes and value/mask mode with enables off.

// File: rtl/iac_pkg.sv
package iac_pkg;

    localparam int NUM_EV    = 4;
    localparam int NUM_PAIRS = NUM_EV / 2;
    localparam int CTRL_W    = NUM_EV + NUM_PAIRS + 2 * NUM_EV;

    typedef enum logic [2:0] {
        SEL_CMP1 = 3'd0,
        SEL_CMP2 = 3'd1,
        SEL_CMP3 = 3'd2,
        SEL_CMP4 = 3'd3,
        SEL_CTRL = 3'd4,
        SEL_CLR  = 3'd5
    } reg_sel_e;

    typedef enum logic [1:0] {
        PRIV_ANY  = 2'b00,
        PRIV_RSVD = 2'b01,
        PRIV_SUP  = 2'b10,
        PRIV_USER = 2'b11
    } priv_e;

    // packed MSB first: qual[3] occupies the top bits, enables the bottom
    typedef struct packed {
        logic [NUM_EV-1:0][1:0]  qual;
        logic [NUM_PAIRS-1:0]    mask_mode;
        logic [NUM_EV-1:0]       en;
    } ctrl_t;

    function automatic logic priv_pass(input logic [1:0] q, input logic user);
        logic ok;
        unique case (priv_e'(q))
            PRIV_ANY:  ok = 1'b1;
            PRIV_SUP:  ok = ~user;
            PRIV_USER: ok = user;
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic logic field_match(input logic [63:0] diff);
        return diff == '0;
    endfunction

endpackage

// File: rtl/iac_regs.sv
module iac_regs
    import iac_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [2:0]                      wr_sel,
    input  logic [ADDR_W-1:0]               wr_data,
    output logic [NUM_EV-1:0][ADDR_W-1:0]   cmp_q,
    output ctrl_t                           ctrl_q
);

    for (genvar k = 0; k < NUM_EV; k++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (rst) begin
                cmp_q[k] <= '0;
            end else if (wr_en && wr_sel == 3'(k)) begin
                cmp_q[k] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en && reg_sel_e'(wr_sel) == SEL_CTRL) begin
            ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

endmodule

// File: rtl/iac_pair.sv
module iac_pair
    import iac_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                addr_valid,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [ADDR_W-1:0]   cmp_keep,
    input  logic                user_mode,
    input  logic [ADDR_W-1:0]   reg_lo,
    input  logic [ADDR_W-1:0]   reg_hi,
    input  logic                mask_mode,
    input  logic [1:0]          en,
    input  logic [1:0][1:0]     qual,
    output logic [1:0]          hit
);

    logic [1:0][ADDR_W-1:0] regs;
    logic [1:0]             exact_hit;
    logic                   masked_hit;

    assign regs[0] = reg_lo;
    assign regs[1] = reg_hi;

    assign masked_hit = field_match(64'((addr ^ reg_lo) & reg_hi & cmp_keep));

    for (genvar e = 0; e < 2; e++) begin : g_ev
        assign exact_hit[e] = field_match(64'((addr ^ regs[e]) & cmp_keep));
        assign hit[e] = addr_valid && en[e] && priv_pass(qual[e], user_mode)
                        && (mask_mode ? masked_hit : exact_hit[e]);
    end

    // value/mask match with both events fully open must hit both or neither
    AST_MASK_PAIR: assert property (@(posedge clk) disable iff (rst)
        (mask_mode && en == 2'b11 && qual[0] == 2'b00 && qual[1] == 2'b00)
        |-> (hit[0] == hit[1])); // R5

endmodule

// File: rtl/iac_status.sv
module iac_status
    import iac_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_EV-1:0]   hits,
    input  logic                clr_en,
    input  logic [NUM_EV-1:0]   clr_bits,
    output logic [NUM_EV-1:0]   status,
    output logic                evt_pulse
);

    logic [NUM_EV-1:0] clr_eff;
    logic [NUM_EV-1:0] fresh;

    assign clr_eff = clr_en ? clr_bits : '0;
    assign fresh   = hits & ~status;

    always_ff @(posedge clk) begin
        if (rst) begin
            status    <= '0;
            evt_pulse <= 1'b0;
        end else begin
            status    <= (status & ~clr_eff) | hits;
            evt_pulse <= |fresh;
        end
    end

    for (genvar k = 0; k < NUM_EV; k++) begin : g_chk
        AST_STICKY_BIT: assert property (@(posedge clk) disable iff (rst)
            (status[k] && !(clr_en && clr_bits[k])) |=> status[k]); // R2
    end

    AST_PULSE_NEWBIT: assert property (@(posedge clk) disable iff (rst)
        evt_pulse |-> ((status & ~$past(status)) != '0)); // R9

endmodule

// File: rtl/iac_debug_unit.sv
module iac_debug_unit
    import iac_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                addr_valid,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                mode32,
    input  logic                user_mode,
    input  logic                wr_en,
    input  logic [2:0]          wr_sel,
    input  logic [ADDR_W-1:0]   wr_data,
    output logic [3:0]          status,
    output logic                dbg_event
);

    localparam int HALF_W = ADDR_W / 2;

    logic [NUM_EV-1:0][ADDR_W-1:0] cmp_q;
    ctrl_t                         ctrl_q;
    logic [ADDR_W-1:0]             cmp_keep;
    logic [NUM_EV-1:0]             hits;

    assign cmp_keep = mode32 ? {{(ADDR_W-HALF_W){1'b0}}, {HALF_W{1'b1}}} : '1;

    iac_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .cmp_q   (cmp_q),
        .ctrl_q  (ctrl_q)
    );

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        iac_pair #(.ADDR_W(ADDR_W)) u_pair (
            .clk        (clk),
            .rst        (rst),
            .addr_valid (addr_valid),
            .addr       (addr),
            .cmp_keep   (cmp_keep),
            .user_mode  (user_mode),
            .reg_lo     (cmp_q[2*p]),
            .reg_hi     (cmp_q[2*p+1]),
            .mask_mode  (ctrl_q.mask_mode[p]),
            .en         (ctrl_q.en[2*p+1 -: 2]),
            .qual       (ctrl_q.qual[2*p+1 -: 2]),
            .hit        (hits[2*p+1 -: 2])
        );
    end

    iac_status u_status (
        .clk       (clk),
        .rst       (rst),
        .hits      (hits),
        .clr_en    (wr_en && reg_sel_e'(wr_sel) == SEL_CLR),
        .clr_bits  (wr_data[NUM_EV-1:0]),
        .status    (status),
        .evt_pulse (dbg_event)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !addr_valid |=> !dbg_event); // R8

    for (genvar k = 0; k < NUM_EV; k++) begin : g_top_chk
        AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (rst)
            (status[k] && !$past(status[k])) |-> $past(ctrl_q.en[k])); // R1
        AST_QUAL_RSVD: assert property (@(posedge clk) disable iff (rst)
            (status[k] && !$past(status[k])) |-> ($past(ctrl_q.qual[k]) != 2'b01)); // R7
    end

endmodule

// File: tb/iac_debug_unit_tb.sv
module iac_debug_unit_tb;

    localparam int AW = 16;
    localparam int HW = AW / 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          addr_valid;
    logic [AW-1:0] addr;
    logic          mode32;
    logic          user_mode;
    logic          wr_en;
    logic [2:0]    wr_sel;
    logic [AW-1:0] wr_data;
    logic [3:0]    status;
    logic          dbg_event;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    iac_debug_unit #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .addr_valid(addr_valid), .addr(addr),
        .mode32(mode32), .user_mode(user_mode), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .status(status), .dbg_event(dbg_event)
    );

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got status/event=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [AW-1:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 3'd7; wr_data = '0;
    endtask

    task automatic present(input logic [AW-1:0] a, input logic v, input logic m32, input logic pr);
        addr_valid = v; addr = a; mode32 = m32; user_mode = pr;
        @(negedge clk);
        addr_valid = 1'b0;
    endtask

    function automatic logic q_ok(input logic [1:0] q, input logic pr);
        if (q == 2'b00) return 1'b1;
        if (q == 2'b10) return !pr;
        if (q == 2'b11) return pr;
        return 1'b0;
    endfunction

    function automatic logic [3:0] model(input logic [3:0][AW-1:0] r, input logic [13:0] c,
                                         input logic [AW-1:0] a, input logic m32, input logic pr);
        logic [AW-1:0] keep;
        logic [3:0] h;
        keep = m32 ? AW'((1 << HW) - 1) : '1;
        for (int e = 0; e < 4; e++) begin
            int p;
            logic m;
            p = e / 2;
            if (c[4 + p])
                m = (((a ^ r[2*p]) & r[2*p+1] & keep) == '0);
            else
                m = (((a ^ r[e]) & keep) == '0);
            h[e] = m && c[e] && q_ok(c[6 + 2*e +: 2], pr);
        end
        return h;
    endfunction

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hung expected done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; addr_valid = 0; addr = '0; mode32 = 0; user_mode = 0;
        wr_en = 0; wr_sel = 3'd7; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R2 reset", {status, dbg_event}, 5'b0);

        // directed: exact hit on event 1, then stickiness
        wr(3'd0, 16'h1234);
        wr(3'd4, 16'h0001);
        present(16'h1234, 1, 0, 0);
        check("R3 exact hit", {status, dbg_event}, 5'b00011);
        present(16'h0000, 1, 0, 0);
        check("R2 sticky / R9 one cycle", {status, dbg_event}, 5'b00010);
        present(16'h1234, 1, 0, 0);
        check("R9 no pulse on already set", {status, dbg_event}, 5'b00010);
        // strobe low: no comparison
        wr(3'd5, 16'h000F);
        present(16'h1234, 0, 0, 0);
        check("R8 strobe low", {status, dbg_event}, 5'b00000);
        // partial clear
        wr(3'd1, 16'h1234);
        wr(3'd4, 16'h0003);
        present(16'h1234, 1, 0, 0);
        check("R1 two exact hits", {status, dbg_event}, 5'b00111);
        wr(3'd5, 16'h0002);
        check("R2 partial clear", {status, dbg_event}, 5'b00010);
        // clear and hit on the same edge: set wins
        wr_en = 1; wr_sel = 3'd5; wr_data = 16'h0001;
        addr_valid = 1; addr = 16'h1234;
        @(negedge clk);
        wr_en = 0; wr_sel = 3'd7; addr_valid = 0;
        check("R2 set beats clear", {status, dbg_event}, 5'b00111);
        // mask mode, both enables clear
        wr(3'd5, 16'h000F);
        wr(3'd4, 16'h0010);
        present(16'h1234, 1, 0, 0);
        check("R10 mask mode no enables", {status, dbg_event}, 5'b00000);
        // write takes effect for later address only
        wr(3'd0, 16'h5555);
        wr(3'd4, 16'h0001);
        present(16'h1234, 1, 0, 0);
        check("R11 updated register", {status, dbg_event}, 5'b00000);
        present(16'h5555, 1, 0, 0);
        check("R11 new value matches", {status, dbg_event}, 5'b00011);

        // sweep
        for (int t = 0; t < 400; t++) begin
            logic [3:0][AW-1:0] r;
            logic [13:0] c;
            logic [AW-1:0] a;
            logic m32, pr;
            logic [3:0] exp_h;
            int sel, kind;
            for (int k = 0; k < 4; k++)
                r[k] = AW'(t * (k + 3) * 40503 + k * 16'h1357 + t);
            c = 14'((t * 2654435) ^ (t << 3));
            m32 = t[6];
            pr = t[7];
            sel = t % 4;
            kind = (t / 4) % 3;
            if (kind == 0) a = r[sel];
            else if (kind == 1) a = r[sel] ^ AW'(((t % 7) + 1) << HW);
            else a = AW'(t * 977 + 5);
            if (c[4] && (t % 5 == 0)) a = (r[0] & r[1]) | (a & ~r[1]);
            if (c[5] && (t % 5 == 1)) a = (r[2] & r[3]) | (a & ~r[3]);
            for (int k = 0; k < 4; k++) wr(3'(k), r[k]);
            wr(3'd4, AW'(c));
            wr(3'd5, 16'h000F);
            present(a, 1, m32, pr);
            exp_h = model(r, c, a, m32, pr);
            check("R1 R3 R4 R5 R6 R7 sweep", {status, dbg_event}, {exp_h, |exp_h});
            @(negedge clk);
            check("R9 pulse ends", {status, dbg_event}, {exp_h, 1'b0});
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule